// File: doc/BRIEF.md
# Streaming NAND Hamming Code Generator

This block computes a three-byte single-error-correcting Hamming code over a 256-byte data block. The block arrives as a byte stream, one byte on each clock where `in_valid` is high. A start strobe marks the first byte. Two kinds of parity are gathered as the bytes go by:

- **Column parity** folds the bit positions inside every byte into six parity bits.
- **Line parity** accumulates the index of every byte whose bits XOR to one, once as-is and once complemented.

When the 256th byte has been taken in, the finished code is latched onto registered outputs and a one-cycle done pulse is raised. A static order input chooses which of the two line-parity bytes comes first. This matches the two byte orders used for flash pages.

The block sits beside a flash page write or read path. On a write the three bytes are stored with the data. On a read the same block recomputes them, and logic outside compares the two.

Top module: `nand_ecc_gen`

## Requirements
- R1: For each accepted byte d, six column bits are formed and XORed into a 6-bit column accumulator. The bits are: bit0 = ^(d & 8'h55), bit1 = ^(d & 8'hAA), bit2 = ^(d & 8'h33), bit3 = ^(d & 8'hCC), bit4 = ^(d & 8'h0F), bit5 = ^(d & 8'hF0). Code byte 2 is {~column[5:0], 2'b11}.
- R2: When the XOR of all eight bits of the byte at index i (0 to 255) is 1, i is XORed into line accumulator A and ~i is XORed into line accumulator B. Bytes of even parity leave A and B unchanged.
- R3: With `sm_order` low, `code0` = ~P and `code1` = ~Q. P = {A[7],B[7],A[6],B[6],A[5],B[5],A[4],B[4]} and Q = {A[3],B[3],A[2],B[2],A[1],B[1],A[0],B[0]}, both MSB first.
- R4: With `sm_order` high, `code0` = ~Q and `code1` = ~P. `sm_order` is sampled in the cycle the last byte is accepted.
- R5: A byte accepted with `in_start` high has index 0, and all three accumulators restart from it. A start in the middle of a block discards the partial block.
- R6: A cycle with `in_valid` low changes no index and no accumulator, even when `in_start` or `in_data` toggle.
- R7: `code_done` is high for exactly one cycle, on the clock after the byte with index 255 is accepted. The codes are registered and hold until the next completion.
- R8: After a completed block, the next accepted byte has index 0 and opens a new block even without a start strobe.
- R9: After synchronous reset, `code_done` is low and all three code outputs are 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A data byte is present this cycle |
| in_start | input | 1 | This byte is the first of a block (honoured only with in_valid) |
| in_data | input | 8 | Data byte |
| sm_order | input | 1 | 0: line bytes in default order, 1: swapped order |
| code0 | output | 8 | Code byte 0 |
| code1 | output | 8 | Code byte 1 |
| code2 | output | 8 | Code byte 2 (column parity) |
| code_done | output | 1 | One-cycle pulse when a new code is presented |

## Verification
All-zero and all-0xFF blocks both give FF/FF/FF. They show that even-parity bytes and balanced columns contribute nothing.

A block that is zero except for one odd byte at index 5 has hand-worked values (AA/99/AB). These values separate A from B, the P/Q interleave, and the column mask assignment.

Random blocks are sent three ways:
- with idle gaps that carry stray start strobes;
- in both byte orders;
- after an abandoned partial block, and as back-to-back blocks without a second strobe.

Together these separate index counting, restart and order swap.

// File: rtl/nand_ecc_pkg.sv
// Shared constants and helpers for the NAND Hamming code generator.
// Assumes 8-bit data bytes and 256-byte blocks, so the byte index is 8 bits wide.
package nand_ecc_pkg;
    localparam int BYTE_W      = 8;
    localparam int COL_W       = 6;
    localparam int BLOCK_BYTES = 256;
    localparam int IDX_W       = $clog2(BLOCK_BYTES);

    // Mask of the data bits covered by column parity bit k.
    // Pair g = k/2 splits bits on bit g of the bit number; odd k takes the set half.
    function automatic logic [BYTE_W-1:0] col_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int b = 0; b < BYTE_W; b++) begin
            m[b] = (((b >> (k / 2)) & 1) == (k % 2));
        end
        return m;
    endfunction

    // Interleave the upper or lower halves of A and B as {A[n],B[n],...}.
    function automatic logic [BYTE_W-1:0] weave(input logic [IDX_W-1:0] a,
                                                input logic [IDX_W-1:0] b,
                                                input bit upper);
        logic [BYTE_W-1:0] w;
        for (int k = 0; k < BYTE_W / 2; k++) begin
            w[2*k+1] = upper ? a[k + BYTE_W/2] : a[k];
            w[2*k]   = upper ? b[k + BYTE_W/2] : b[k];
        end
        return w;
    endfunction
endpackage

// File: rtl/ecc_byte_parity.sv
// Per-byte parity terms: six column parities and the whole-byte parity.
// Purely combinational; assumes BYTE_W = 8.
module ecc_byte_parity
    import nand_ecc_pkg::*;
(
    input  logic [BYTE_W-1:0] data_in,
    output logic [COL_W-1:0]  col_bits,
    output logic              odd_byte
);
    // One reduction XOR per column parity bit.
    for (genvar k = 0; k < COL_W; k++) begin : g_col
        assign col_bits[k] = ^(data_in & col_mask(k));
    end

    // Whole-byte parity selects the byte for line parity.
    assign odd_byte = ^data_in;
endmodule

// File: rtl/ecc_index_ctrl.sv
// Byte index tracking: a start strobe forces index 0, and the index wraps after the last byte.
// Assumes in_start is only meaningful when in_valid is high.
module ecc_index_ctrl
    import nand_ecc_pkg::*;
#(
    parameter int NBYTES = BLOCK_BYTES,
    localparam int IW    = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    output logic          accept,
    output logic          first,
    output logic          last,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] cnt_q;

    // Index of the byte on the inputs this cycle.
    always_comb begin
        idx    = in_start ? '0 : cnt_q;
        accept = in_valid;
        first  = in_valid && (idx == '0);
        last   = in_valid && (idx == IW'(NBYTES - 1));
    end

    // Advance the index on each accepted byte, wrapping after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (accept)
            cnt_q <= last ? '0 : idx + IW'(1);
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt_q));
    // R5
    restart_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start) |=> (cnt_q == IW'(1)));
endmodule

// File: rtl/ecc_accum.sv
// Column and line parity accumulators, plus the registered code output stage.
// Assumes the index width equals the byte width (8), which the P/Q interleave needs.
module ecc_accum
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             first,
    input  logic             last,
    input  logic [IDX_W-1:0] idx,
    input  logic [COL_W-1:0] col_in,
    input  logic             odd_in,
    input  logic             sm_order,
    output logic [7:0]       code0,
    output logic [7:0]       code1,
    output logic [7:0]       code2,
    output logic             code_done
);
    logic [COL_W-1:0] col_q, col_nx;
    logic [IDX_W-1:0] a_q, b_q, a_nx, b_nx;
    logic [7:0]       p_w, q_w;

    // Next accumulator values; the first byte of a block starts from zero.
    always_comb begin
        col_nx = (first ? '0 : col_q) ^ col_in;
        a_nx   = (first ? '0 : a_q) ^ (odd_in ? idx : '0);
        b_nx   = (first ? '0 : b_q) ^ (odd_in ? ~idx : '0);
        p_w    = weave(a_nx, b_nx, 1'b1);
        q_w    = weave(a_nx, b_nx, 1'b0);
    end

    // Accumulate on accepted bytes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else if (accept) begin
            col_q <= col_nx;
            a_q   <= a_nx;
            b_q   <= b_nx;
        end
    end

    // Latch the finished code and pulse done when the last byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code0     <= '0;
            code1     <= '0;
            code2     <= '0;
            code_done <= 1'b0;
        end else begin
            code_done <= accept && last;
            if (accept && last) begin
                code0 <= sm_order ? ~q_w : ~p_w;
                code1 <= sm_order ? ~p_w : ~q_w;
                code2 <= {~col_nx, 2'b11};
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_done |=> !code_done);
    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_done |-> ($stable(code0) && $stable(code1) && $stable(code2)));
    // R1
    fill_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_done |-> (code2[1:0] == 2'b11));
    // R6
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(col_q) && $stable(a_q) && $stable(b_q)));
    // R3
    line_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !first) |=> ((a_q ^ b_q) == ((a_q[0] ^ b_q[0]) ? '1 : '0)));
endmodule

// File: rtl/nand_ecc_gen.sv
// Top level: streaming Hamming code generator over 256-byte blocks.
// Assumes sm_order is static, or at least stable when a block completes.
module nand_ecc_gen
    import nand_ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_start,
    input  logic [7:0]  in_data,
    input  logic        sm_order,
    output logic [7:0]  code0,
    output logic [7:0]  code1,
    output logic [7:0]  code2,
    output logic        code_done
);
    logic             accept, first, last, odd_byte;
    logic [IDX_W-1:0] idx;
    logic [COL_W-1:0] col_bits;

    ecc_byte_parity u_par (
        .data_in  (in_data),
        .col_bits (col_bits),
        .odd_byte (odd_byte)
    );

    ecc_index_ctrl #(.NBYTES(BLOCK_BYTES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .accept   (accept),
        .first    (first),
        .last     (last),
        .idx      (idx)
    );

    ecc_accum u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .first     (first),
        .last      (last),
        .idx       (idx),
        .col_in    (col_bits),
        .odd_in    (odd_byte),
        .sm_order  (sm_order),
        .code0     (code0),
        .code1     (code1),
        .code2     (code2),
        .code_done (code_done)
    );

    // R7
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_done |-> $past(in_valid));
endmodule

// File: tb/nand_ecc_gen_bench.sv
// Directed bench for nand_ecc_gen: one task per scenario, checked against a bench-side model.
module nand_ecc_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       sm_order = 1'b0;
    logic [7:0] code0, code1, code2;
    logic       code_done;

    int checks = 0;
    int errors = 0;
    logic [7:0] blk [256];

    always #2 clk = ~clk;

    nand_ecc_gen u_nand_ecc_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_data(in_data), .sm_order(sm_order), .code0(code0), .code1(code1),
        .code2(code2), .code_done(code_done)
    );

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench model of the code for blk[], written from the requirement text.
    function automatic logic [23:0] model(input bit sm);
        logic [5:0] col = '0;
        logic [7:0] a = '0, b = '0, p, q;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d = blk[i];
            col ^= {^(d & 8'hF0), ^(d & 8'h0F), ^(d & 8'hCC), ^(d & 8'h33), ^(d & 8'hAA), ^(d & 8'h55)};
            if (^d) begin
                a ^= 8'(i);
                b ^= ~8'(i);
            end
        end
        p = {a[7], b[7], a[6], b[6], a[5], b[5], a[4], b[4]};
        q = {a[3], b[3], a[2], b[2], a[1], b[1], a[0], b[0]};
        return sm ? {~q, ~p, ~col, 2'b11} : {~p, ~q, ~col, 2'b11};
    endfunction

    // Stream blk[]; optional idle gaps with stray strobes; check the result and the done pulse.
    task automatic send_block(input bit sm, input bit gaps, input bit use_start, input string req);
        logic [23:0] exp = model(sm);
        sm_order = sm;
        for (int i = 0; i < 256; i++) begin
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0; in_start = 1'b1; in_data = 8'($urandom);   // R6 ignored
            end
            @(negedge clk);
            if (i == 255) chk(code_done == 1'b0, "R7 early", {23'b0, code_done}, 24'h0);
            in_valid = 1'b1; in_start = use_start && (i == 0); in_data = blk[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        chk(code_done == 1'b1, "R7 done", {23'b0, code_done}, 24'h1);
        chk({code0, code1, code2} == exp, req, {code0, code1, code2}, exp);
        @(negedge clk);
        chk(code_done == 1'b0, "R7 pulse", {23'b0, code_done}, 24'h0);
        chk({code0, code1, code2} == exp, "R7 hold", {code0, code1, code2}, exp);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({code0, code1, code2, 7'b0, code_done} == 32'h0, "R9 reset", {code0, code1, code2}, 24'h0);
    endtask

    task automatic t_zero_ones();
        foreach (blk[i]) blk[i] = 8'h00;
        send_block(1'b0, 1'b0, 1'b1, "R1 R2 zero block");
        foreach (blk[i]) blk[i] = 8'hFF;
        send_block(1'b0, 1'b0, 1'b1, "R1 R2 ones block");
    endtask

    task automatic t_single_odd();
        foreach (blk[i]) blk[i] = 8'h00;
        blk[5] = 8'h01;
        chk(model(1'b0) == 24'hAA99AB, "R3 model", model(1'b0), 24'hAA99AB);
        send_block(1'b0, 1'b0, 1'b1, "R3 single odd byte");
        send_block(1'b1, 1'b0, 1'b1, "R4 single odd swapped");
        chk({code0, code1, code2} == 24'h99AAAB, "R4 swap value", {code0, code1, code2}, 24'h99AAAB);
    endtask

    task automatic t_random_gaps();
        foreach (blk[i]) blk[i] = 8'($urandom);
        send_block(1'b0, 1'b1, 1'b1, "R6 random with gaps");
        send_block(1'b1, 1'b0, 1'b1, "R4 random swapped");
    endtask

    task automatic t_restart();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = (i == 0); in_data = 8'($urandom);
        end
        foreach (blk[i]) blk[i] = 8'($urandom);
        send_block(1'b0, 1'b0, 1'b1, "R5 mid-block restart");
    endtask

    task automatic t_back_to_back();
        foreach (blk[i]) blk[i] = 8'($urandom);
        send_block(1'b0, 1'b0, 1'b1, "R8 first block");
        foreach (blk[i]) blk[i] = 8'($urandom);
        send_block(1'b0, 1'b0, 1'b0, "R8 no-strobe block");
    endtask

    initial begin
        t_reset();
        t_zero_ones();
        t_single_odd();
        t_random_gaps();
        t_restart();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule